// File: doc/BRIEF.md
# Hysteretic Frequency Lock Detector

This block decides whether a feedback clock runs at the frequency of a reference clock. It counts feedback edges over a fixed span of reference cycles and compares the count with the nominal count for that span. A deviation inside a narrow tolerance declares lock. Only a deviation beyond a wider tolerance withdraws it. Deviations between the two tolerances leave the flag as it is, so a clock near a limit cannot make the flag chatter.

The feedback edge count lives in the feedback domain. It reaches the reference domain through a request/acknowledge toggle pair with two-flop synchronisers, so the comparison only ever sees a finished, stable count. The lock flag is active-low and registered in the reference domain. It is a standalone lock result and feeds nothing else. A synchronous active-high reset from the power-on sequencer holds the detector unlocked. It must stay high for several cycles of both clocks.

Top module: `freq_lock_detect`

## Requirements
- R1: While `rst` is high, `lock_n` is 1 from the next reference edge on, and the detector leaves reset in the unlocked state.
- R2: A window lasts 2^WIN_BITS reference cycles. The measurement for a window is the number of feedback edges between two consecutive window ends, compared with the nominal count 2^WIN_BITS. Starting from reset with a matching feedback clock, lock is first declared between 2*2^WIN_BITS and 2*2^WIN_BITS+28 reference cycles after reset release.
- R3: A measurement whose absolute deviation from nominal is at most LOCK_TOL counts drives `lock_n` to 0 (locked).
- R4: A measurement whose absolute deviation exceeds UNLOCK_TOL counts drives `lock_n` to 1 (unlocked).
- R5: A measurement whose deviation is above LOCK_TOL and at most UNLOCK_TOL leaves `lock_n` unchanged, whether the detector is locked or unlocked.
- R6: No lock is declared before two window ends have passed after reset release. The first completed window only provides the baseline count.
- R7: If a window ends while the previous count request has not been acknowledged (no feedback edges arrived), that window counts as out of tolerance and `lock_n` goes to 1.
- R8: `lock_n` changes only in the cycle after a measurement result and stays stable between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; defines the window and the flag's domain |
| clk_fb | input | 1 | Feedback clock under test |
| rst | input | 1 | Synchronous active-high reset from the power-on sequencer |
| lock_n | output | 1 | Lock flag: 0 locked, 1 unlocked |

## Verification
The bench sweeps the feedback offset across the whole band, one count at a time, starting once from the locked state and once from the unlocked state. Offsets within one count of either limit are skipped, because window phase blurs the count by one edge. A design that used a single threshold, or swapped the two, fails the hold points of the sweep: it unlocks at small offsets or relocks in the hold band. The bench times the first lock after reset, which exposes a detector that trusts its first, baseline window or that uses the wrong window length. It also stops the feedback clock completely. A detector that waits forever for an acknowledge would then keep a stale lock.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic [1:0] {
        BAND_IN   = 2'd0,
        BAND_HOLD = 2'd1,
        BAND_OUT  = 2'd2
    } band_e;

    typedef struct packed {
        logic  vld;
        band_e band;
    } meas_t;

    // Place a count relative to nominal in one of three tolerance bands.
    function automatic band_e classify(input int unsigned count,
                                       input int unsigned nominal,
                                       input int unsigned tol_in,
                                       input int unsigned tol_out);
        int unsigned dev;
        dev = (count > nominal) ? (count - nominal) : (nominal - count);
        if (dev <= tol_in)
            return BAND_IN;
        else if (dev > tol_out)
            return BAND_OUT;
        return BAND_HOLD;
    endfunction

endpackage

// File: rtl/fld_window_gen.sv
module fld_window_gen #(
    parameter int WIN_BITS = 16
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    logic [WIN_BITS-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            win_end <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            win_end <= (cnt_q == {WIN_BITS{1'b1}});
        end
    end

    // R2: window end is a single-cycle pulse
    a_r2_win_pulse: assert property (@(posedge clk) disable iff (rst)
        win_end |=> !win_end);

endmodule

// File: rtl/fld_fb_sampler.sv
module fld_fb_sampler #(
    parameter int CW = 19
) (
    input  logic          clk_fb,
    input  logic          rst,
    input  logic          req_tgl,
    output logic          ack_tgl,
    output logic [CW-1:0] snap
);
    logic [CW-1:0] edge_cnt_q;
    logic          req_s1, req_s2, req_seen;

    always_ff @(posedge clk_fb) begin
        if (rst) begin
            edge_cnt_q <= '0;
            req_s1     <= 1'b0;
            req_s2     <= 1'b0;
            req_seen   <= 1'b0;
            ack_tgl    <= 1'b0;
            snap       <= '0;
        end else begin
            edge_cnt_q <= edge_cnt_q + 1'b1;
            req_s1     <= req_tgl;
            req_s2     <= req_s1;
            req_seen   <= req_s2;
            if (req_s2 != req_seen) begin
                snap    <= edge_cnt_q;
                ack_tgl <= ~ack_tgl;
            end
        end
    end

    // R2: an acknowledge only answers a newly synchronised request
    a_r2_ack_on_req: assert property (@(posedge clk_fb) disable iff (rst)
        (req_s2 == req_seen) |=> $stable(ack_tgl));

    // R2: the snapshot stays frozen while no request is being answered
    a_r2_snap_stable: assert property (@(posedge clk_fb) disable iff (rst)
        (req_s2 == req_seen) |=> $stable(snap));

endmodule

// File: rtl/fld_meas.sv
module fld_meas
    import fld_pkg::*;
#(
    parameter int WIN_BITS   = 16,
    parameter int CW         = 19,
    parameter int LOCK_TOL   = 33,
    parameter int UNLOCK_TOL = 52
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win_end,
    output logic          req_tgl,
    input  logic          ack_tgl,
    input  logic [CW-1:0] snap,
    output meas_t         meas
);
    localparam int unsigned NOMINAL = 32'd1 << WIN_BITS;

    logic          ack_s1, ack_s2, ack_seen, have_base;
    logic [CW-1:0] base_q;
    logic [CW-1:0] delta;
    logic          ack_chg, pending;

    assign ack_chg = (ack_s2 != ack_seen);
    assign pending = (req_tgl != (ack_chg ? ack_s2 : ack_seen));
    assign delta   = snap - base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_s1    <= 1'b0;
            ack_s2    <= 1'b0;
            ack_seen  <= 1'b0;
            have_base <= 1'b0;
            base_q    <= '0;
            req_tgl   <= 1'b0;
            meas      <= '{vld: 1'b0, band: BAND_IN};
        end else begin
            ack_s1 <= ack_tgl;
            ack_s2 <= ack_s1;
            meas   <= '{vld: 1'b0, band: BAND_IN};
            if (ack_chg) begin
                ack_seen  <= ack_s2;
                base_q    <= snap;
                have_base <= 1'b1;
                if (have_base)
                    meas <= '{vld: 1'b1,
                              band: classify(32'(delta), NOMINAL,
                                             LOCK_TOL, UNLOCK_TOL)};
            end
            if (win_end) begin
                if (pending) begin
                    have_base <= 1'b0;
                    meas      <= '{vld: 1'b1, band: BAND_OUT};
                end else begin
                    req_tgl <= ~req_tgl;
                end
            end
        end
    end

    // R7: a window closing on an unanswered request is a failed measurement
    a_r7_dead_window: assert property (@(posedge clk) disable iff (rst)
        (win_end && pending) |=> (meas.vld && meas.band == BAND_OUT));

    // R6: a result needs a new acknowledge or a window end in the prior cycle
    a_r6_result_source: assert property (@(posedge clk) disable iff (rst)
        (!ack_chg && !win_end) |=> !meas.vld);

endmodule

// File: rtl/fld_lock_fsm.sv
module fld_lock_fsm
    import fld_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  meas_t meas,
    output logic  lock_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_n <= 1'b1;
        end else if (meas.vld) begin
            case (meas.band)
                BAND_IN:  lock_n <= 1'b0;
                BAND_OUT: lock_n <= 1'b1;
                default:  lock_n <= lock_n;
            endcase
        end
    end

    // R1: reset forces the unlocked flag
    a_r1_reset_unlocked: assert property (@(posedge clk)
        rst |=> lock_n);

    // R3: an in-band result locks
    a_r3_enter_lock: assert property (@(posedge clk) disable iff (rst)
        (meas.vld && meas.band == BAND_IN) |=> !lock_n);

    // R4: an out-of-band result unlocks
    a_r4_leave_lock: assert property (@(posedge clk) disable iff (rst)
        (meas.vld && meas.band == BAND_OUT) |=> lock_n);

    // R5: a hold-band result keeps the flag
    a_r5_hold_band: assert property (@(posedge clk) disable iff (rst)
        (meas.vld && meas.band == BAND_HOLD) |=> $stable(lock_n));

    // R8: no result, no change
    a_r8_stable_between: assert property (@(posedge clk) disable iff (rst)
        !meas.vld |=> $stable(lock_n));

endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect
    import fld_pkg::*;
#(
    parameter int WIN_BITS   = 16,
    parameter int LOCK_TOL   = 33,
    parameter int UNLOCK_TOL = 52
) (
    input  logic clk_ref,
    input  logic clk_fb,
    input  logic rst,
    output logic lock_n
);
    localparam int CW = WIN_BITS + 3;

    logic          win_end;
    logic          req_tgl;
    logic          ack_tgl;
    logic [CW-1:0] snap;
    meas_t         meas;

    fld_window_gen #(.WIN_BITS(WIN_BITS)) u_win (
        .clk     (clk_ref),
        .rst     (rst),
        .win_end (win_end)
    );

    fld_fb_sampler #(.CW(CW)) u_fb (
        .clk_fb  (clk_fb),
        .rst     (rst),
        .req_tgl (req_tgl),
        .ack_tgl (ack_tgl),
        .snap    (snap)
    );

    fld_meas #(
        .WIN_BITS   (WIN_BITS),
        .CW         (CW),
        .LOCK_TOL   (LOCK_TOL),
        .UNLOCK_TOL (UNLOCK_TOL)
    ) u_meas (
        .clk     (clk_ref),
        .rst     (rst),
        .win_end (win_end),
        .req_tgl (req_tgl),
        .ack_tgl (ack_tgl),
        .snap    (snap),
        .meas    (meas)
    );

    fld_lock_fsm u_fsm (
        .clk    (clk_ref),
        .rst    (rst),
        .meas   (meas),
        .lock_n (lock_n)
    );

endmodule

// File: tb/test_freq_lock_detect.sv
`timescale 1ns/1ps
module test_freq_lock_detect;

    localparam int WB     = 8;
    localparam int WIN    = 1 << WB;
    localparam int TOL_IN = 4;
    localparam int TOL_OUT = 8;

    logic clk_ref = 1'b0;
    logic clk_fb  = 1'b0;
    logic rst     = 1'b1;
    logic lock_n;

    real fb_half = 5.0;
    bit  fb_run  = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    freq_lock_detect #(
        .WIN_BITS   (WB),
        .LOCK_TOL   (TOL_IN),
        .UNLOCK_TOL (TOL_OUT)
    ) i_freq_lock_detect (
        .clk_ref (clk_ref),
        .clk_fb  (clk_fb),
        .rst     (rst),
        .lock_n  (lock_n)
    );

    always #5 clk_ref = ~clk_ref;

    always begin
        if (fb_run) #(fb_half) clk_fb = ~clk_fb;
        else #1;
    end

    always @(posedge clk_ref) begin
        cyc++;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // feedback period giving WIN+d edges per reference window
    task automatic set_dev(input int d);
        fb_half = (real'(WIN) * 10.0) / (real'(WIN) + real'(d)) / 2.0;
    endtask

    task automatic settle(input int windows);
        repeat (windows * WIN + 20) @(posedge clk_ref);
        @(negedge clk_ref);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lock_n actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int lo, input int hi, input string tag);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    function automatic logic exp_flag(input int d, input logic start);
        int a;
        a = (d < 0) ? -d : d;
        if (a <= TOL_IN) return 1'b0;
        if (a > TOL_OUT) return 1'b1;
        return start;
    endfunction

    initial begin
        int first_lock;
        int changes;
        logic prev;

        set_dev(0);
        repeat (20) @(posedge clk_ref);
        @(negedge clk_ref);
        chk(lock_n, 1'b1, "R1 reset state");

        // R2 / R6: first lock timing after reset release
        rst = 1'b0;
        first_lock = 0;
        while (lock_n !== 1'b0 && first_lock < 2000) begin
            @(negedge clk_ref);
            first_lock++;
        end
        chk_int(first_lock, 2 * WIN, 2 * WIN + 28, "R2 R6 first lock cycle");

        // R8: steady matching clock, no toggling over three windows
        changes = 0;
        prev = lock_n;
        repeat (3 * WIN) begin
            @(negedge clk_ref);
            if (lock_n !== prev) changes++;
            prev = lock_n;
        end
        chk_int(changes, 0, 0, "R8 stable while locked");
        chk(lock_n, 1'b0, "R3 steady lock");

        // sweep of offsets, from locked and from unlocked
        for (int d = -13; d <= 13; d++) begin
            int a;
            a = (d < 0) ? -d : d;
            if (a == 4 || a == 5 || a == 8 || a == 9) continue;
            set_dev(0);
            settle(3);
            chk(lock_n, 1'b0, $sformatf("R3 preset lock before d=%0d", d));
            set_dev(d);
            settle(3);
            chk(lock_n, exp_flag(d, 1'b0),
                $sformatf("R3 R4 R5 from locked d=%0d", d));
            set_dev(20);
            settle(3);
            chk(lock_n, 1'b1, $sformatf("R4 preset unlock before d=%0d", d));
            set_dev(d);
            settle(3);
            chk(lock_n, exp_flag(d, 1'b1),
                $sformatf("R3 R4 R5 from unlocked d=%0d", d));
        end

        // R5 / R8: hold band from unlocked, flag stays 1 each cycle
        set_dev(20);
        settle(3);
        set_dev(6);
        settle(3);
        changes = 0;
        repeat (3 * WIN) begin
            @(negedge clk_ref);
            if (lock_n !== 1'b1) changes++;
        end
        chk_int(changes, 0, 0, "R5 R8 hold band keeps unlocked");

        // R7: dead feedback clock
        set_dev(0);
        settle(3);
        chk(lock_n, 1'b0, "R3 lock before dead clock");
        fb_run = 1'b0;
        settle(3);
        chk(lock_n, 1'b1, "R7 dead feedback clock unlocks");
        fb_run = 1'b1;
        settle(4);
        chk(lock_n, 1'b0, "R3 relock after clock returns");

        // R1: reset while locked
        rst = 1'b1;
        repeat (2) @(posedge clk_ref);
        @(negedge clk_ref);
        chk(lock_n, 1'b1, "R1 reset while locked");
        repeat (10) @(posedge clk_ref);
        rst = 1'b0;
        repeat (WIN + 100) @(posedge clk_ref);
        @(negedge clk_ref);
        chk(lock_n, 1'b1, "R6 no lock after one window");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule